// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits between a bank of three-channel 16-bit counter chips and everything that can drive their clock and gate inputs. For every counter channel it holds a 5-bit clock-source code and a 5-bit gate-source code. From those codes it picks one clock-enable level and one gate level out of a fixed set of candidates:

- the channel's own connector pins
- a chip-wide external clock pin
- a set of internal divided clock enables
- constant levels
- the outputs of other counter channels
- a pattern-present input and two pattern-event latches that the block keeps per channel

The counter chips are chained in a ring. A channel can be clocked by the channel one position before it and gated by the channel two positions before it. Counting runs across chip boundaries, and the last chip wraps round to the first.

Each channel's clock pin and gate pin on the connector is bidirectional. The pin is an input only while its own source is selected. Otherwise the block turns the pin into an output and drives the selected level onto it. A `ENHANCED` parameter picks between the basic code set, where only codes 0 to 7 are stored, and the full 32-code set with extra sources. Configuration is plain control: a single write strobe with channel index, register select and data, and a combinational readback addressed by channel. There is no handshake, and a write always completes in the cycle it is presented.

Top module: `ctr_route_matrix`

## Requirements
- R1: After reset every clock code reads 0 and every gate code reads 0. Each channel's clock follows its own clock pin, each gate is high, every clock pin is an input (`clk_pin_oe`=0) and every gate pin is an output (`gat_pin_oe`=1).
- R2: Clock codes select as follows. 0 selects the channel's clock pin. 1, 2, 3, 4 and 5 select `int_ce` bits 0, 1, 2, 3 and 4 (10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz). 7 selects `ext_clk_in` of the channel's chip, where chip = channel / 3.
- R3: With ENHANCED=1, further clock codes are defined. Code 8 gives constant 1, code 9 gives constant 0, code 10 gives `pat_present` and code 11 gives `int_ce` bit 5 (20 MHz). Codes 12 to 31 give constant 0.
- R4: Gate codes select as follows. 0 gives constant 1, 1 gives constant 0 and 2 gives the channel's gate pin.
- R5: With ENHANCED=1, further gate codes are defined. Code 6 gives the inverted gate pin and code 8 gives `pat_present`. Code 9 gives the occurred latch and code 10 gives the inverse of the gone latch. Codes 11, 12 and 13 give the inverses of codes 8, 9 and 10. Codes 4, 5 and 14 to 31 give constant 0.
- R6: With ENHANCED=0, a write whose data exceeds 7 leaves that register unchanged, and gate codes 4 to 7 give constant 0.
- R7: Clock code 6 selects `ctr_out` of channel (n-1) mod total channels. For channel 0 of a chip this is channel 2 of the previous chip, and chip 0 wraps to the last chip.
- R8: Gate code 3 selects the inverse of `ctr_out` of channel (n-2) mod total channels. With ENHANCED=1, gate code 7 selects the same output without inversion. For channel 2 of a chip this is channel 0 of the same chip, and for channels 0 and 1 it is channel n+1 of the previous chip.
- R9: `clk_pin_oe` is high exactly when the clock code is not 0, and `gat_pin_oe` is high exactly when the gate code is not 2. While a pin is an output, its `*_pin_out` equals that channel's selected clock or gate.
- R10: The occurred latch of a channel sets at the first clock edge where `pat_present` is 1. It then stays set.
- R11: The gone latch of a channel sets at a clock edge where the occurred latch is already set and `pat_present` is 0. It then stays set.
- R12: An accepted write to a channel's gate code clears both of that channel's latches at that edge, taking priority over setting them.
- R13: Readback returns the stored clock and gate codes of channel `rd_ch`, and 0 when `rd_ch` is out of range. A write is visible on readback after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one source register |
| cfg_is_gate | input | 1 | 1 writes the gate code, 0 writes the clock code |
| cfg_ch | input | CH_W | Channel index of the write |
| cfg_wdata | input | 5 | Code to write |
| rd_ch | input | CH_W | Channel index for readback |
| rd_clk_code | output | 5 | Stored clock code of `rd_ch` |
| rd_gate_code | output | 5 | Stored gate code of `rd_ch` |
| int_ce | input | 6 | Internal clock enables: 10 MHz, 1 MHz, 100 kHz, 10 kHz, 1 kHz, 20 MHz in bits 0 to 5 |
| clk_pin_in | input | NCH | Per-channel clock pin, input side |
| gat_pin_in | input | NCH | Per-channel gate pin, input side |
| ext_clk_in | input | N_CHIPS | Shared external clock pin of each chip |
| ctr_out | input | NCH | Counter outputs, channel index = chip*3 + local channel |
| pat_present | input | 1 | Pattern-present level from the pattern detector |
| sel_clk | output | NCH | Selected clock enable per channel |
| sel_gate | output | NCH | Selected gate per channel |
| clk_pin_oe | output | NCH | Clock pin output enable |
| clk_pin_out | output | NCH | Clock pin output value |
| gat_pin_oe | output | NCH | Gate pin output enable |
| gat_pin_out | output | NCH | Gate pin output value |

## Verification
The bench builds two copies with two counter chips each (six channels): one with ENHANCED=1 and one with ENHANCED=0, both fed the same stimulus. Two chips is the smallest ring where the chip-0 and chip-1 wrap of both the n-1 clock link and the n-2 gate link can be seen. Six channels are few enough that every channel is swept through all 32 clock codes and all 32 gate codes, each under several computed input patterns. The basic copy shows that out-of-range writes are dropped and the reserved gate codes give 0. Directed pulse sequences on `pat_present` check the set, hold and clear timing of both pattern latches, edge by edge.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int CODE_W      = 5;
  localparam int CH_PER_CHIP = 3;
  localparam int N_INT_CE    = 6;

  // clock source codes
  localparam logic [CODE_W-1:0] CK_PIN   = 5'd0;
  localparam logic [CODE_W-1:0] CK_10M   = 5'd1;
  localparam logic [CODE_W-1:0] CK_1M    = 5'd2;
  localparam logic [CODE_W-1:0] CK_100K  = 5'd3;
  localparam logic [CODE_W-1:0] CK_10K   = 5'd4;
  localparam logic [CODE_W-1:0] CK_1K    = 5'd5;
  localparam logic [CODE_W-1:0] CK_PREV  = 5'd6;
  localparam logic [CODE_W-1:0] CK_EXT   = 5'd7;
  localparam logic [CODE_W-1:0] CK_HIGH  = 5'd8;
  localparam logic [CODE_W-1:0] CK_LOW   = 5'd9;
  localparam logic [CODE_W-1:0] CK_PAT   = 5'd10;
  localparam logic [CODE_W-1:0] CK_20M   = 5'd11;

  // gate source codes
  localparam logic [CODE_W-1:0] GT_ON     = 5'd0;
  localparam logic [CODE_W-1:0] GT_OFF    = 5'd1;
  localparam logic [CODE_W-1:0] GT_PIN    = 5'd2;
  localparam logic [CODE_W-1:0] GT_BACK_N = 5'd3;
  localparam logic [CODE_W-1:0] GT_PIN_N  = 5'd6;
  localparam logic [CODE_W-1:0] GT_BACK   = 5'd7;
  localparam logic [CODE_W-1:0] GT_PAT    = 5'd8;
  localparam logic [CODE_W-1:0] GT_OCC    = 5'd9;
  localparam logic [CODE_W-1:0] GT_STAY   = 5'd10;
  localparam logic [CODE_W-1:0] GT_PAT_N  = 5'd11;
  localparam logic [CODE_W-1:0] GT_OCC_N  = 5'd12;
  localparam logic [CODE_W-1:0] GT_STAY_N = 5'd13;

  // highest code the basic set can store
  localparam int BASIC_MAX = 7;

  // index of each rate in the internal enable vector
  localparam int CE_10M  = 0;
  localparam int CE_1M   = 1;
  localparam int CE_100K = 2;
  localparam int CE_10K  = 3;
  localparam int CE_1K   = 4;
  localparam int CE_20M  = 5;

endpackage

// File: rtl/ctr_src_regs.sv
module ctr_src_regs
  import ctr_route_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int CH_W     = 3,
  parameter bit ENHANCED = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic                         is_gate,
  input  logic [CH_W-1:0]              ch,
  input  logic [CODE_W-1:0]            wdata,
  input  logic [CH_W-1:0]              rd_ch,
  output logic [NCH-1:0][CODE_W-1:0]   clk_code,
  output logic [NCH-1:0][CODE_W-1:0]   gate_code,
  output logic [NCH-1:0]               gate_wr,
  output logic [CODE_W-1:0]            rd_clk_code,
  output logic [CODE_W-1:0]            rd_gate_code
);

  localparam logic [CH_W:0] NCH_LIM = (CH_W+1)'(NCH);

  logic            accept;
  logic [NCH-1:0]  hit;
  logic [CODE_W-1:0] ck_q [NCH];
  logic [CODE_W-1:0] gt_q [NCH];

  // the basic code set keeps only three bits worth of codes
  generate
    if (ENHANCED) begin : g_acc_full
      assign accept = 1'b1;
    end else begin : g_acc_basic
      assign accept = (wdata[CODE_W-1:3] == '0);
    end
  endgenerate

  always_comb begin
    for (int g = 0; g < NCH; g++) begin
      hit[g]     = we && accept && (ch == CH_W'(g));
      gate_wr[g] = hit[g] && is_gate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NCH; g++) begin
        ck_q[g] <= '0;
        gt_q[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NCH; g++) begin
        if (hit[g]) begin
          if (is_gate) gt_q[g] <= wdata;
          else         ck_q[g] <= wdata;
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NCH; g++) begin
      clk_code[g]  = ck_q[g];
      gate_code[g] = gt_q[g];
    end
  end

  always_comb begin
    rd_clk_code  = '0;
    rd_gate_code = '0;
    if ({1'b0, rd_ch} < NCH_LIM) begin
      rd_clk_code  = ck_q[rd_ch];
      rd_gate_code = gt_q[rd_ch];
    end
  end

  generate
    if (!ENHANCED) begin : g_basic_chk
      for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R6: writes beyond the basic set leave both registers alone
        a_r6_basic_hold: assert property (@(posedge clk) disable iff (!rst_n)
          (we && ch == CH_W'(g) && wdata[CODE_W-1:3] != '0)
          |=> (ck_q[g] == $past(ck_q[g]) && gt_q[g] == $past(gt_q[g])));
      end
    end
  endgenerate

endmodule

// File: rtl/pat_event_latch.sv
module pat_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pat,
  output logic occ_q,
  output logic gone_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      gone_q <= 1'b0;
    end else if (clr) begin
      occ_q  <= 1'b0;
      gone_q <= 1'b0;
    end else begin
      if (pat)           occ_q  <= 1'b1;
      if (occ_q && !pat) gone_q <= 1'b1;
    end
  end

  // R12: a rewrite of the gate code empties both latches
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!occ_q && !gone_q));

  // R10: once set, the occurred latch only drops on a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !clr) |=> occ_q);

  // R11: the gone latch never leads the occurred latch
  a_r11_gone_after_occ: assert property (@(posedge clk) disable iff (!rst_n)
    gone_q |-> occ_q);

  // R10: a present pattern is captured at the next edge
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (pat && !clr) |=> occ_q);

endmodule

// File: rtl/ctr_clk_mux.sv
module ctr_clk_mux
  import ctr_route_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic [CODE_W-1:0]   code,
  input  logic                pin,
  input  logic [N_INT_CE-1:0] int_ce,
  input  logic                prev_out,
  input  logic                ext_clk,
  input  logic                pat,
  output logic                sel
);

  logic base_sel;
  logic ext_sel;

  always_comb begin
    base_sel = 1'b0;
    case (code)
      CK_PIN:  base_sel = pin;
      CK_10M:  base_sel = int_ce[CE_10M];
      CK_1M:   base_sel = int_ce[CE_1M];
      CK_100K: base_sel = int_ce[CE_100K];
      CK_10K:  base_sel = int_ce[CE_10K];
      CK_1K:   base_sel = int_ce[CE_1K];
      CK_PREV: base_sel = prev_out;
      CK_EXT:  base_sel = ext_clk;
      default: base_sel = 1'b0;
    endcase
  end

  always_comb begin
    ext_sel = 1'b0;
    case (code)
      CK_HIGH: ext_sel = 1'b1;
      CK_LOW:  ext_sel = 1'b0;
      CK_PAT:  ext_sel = pat;
      CK_20M:  ext_sel = int_ce[CE_20M];
      default: ext_sel = 1'b0;
    endcase
  end

  generate
    if (ENHANCED) begin : g_full
      assign sel = (code > 5'(BASIC_MAX)) ? ext_sel : base_sel;
    end else begin : g_basic
      assign sel = (code > 5'(BASIC_MAX)) ? 1'b0 : base_sel;
    end
  endgenerate

endmodule

// File: rtl/ctr_gate_mux.sv
module ctr_gate_mux
  import ctr_route_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              pin,
  input  logic              back_out,
  input  logic              pat,
  input  logic              occ,
  input  logic              gone,
  output logic              sel
);

  logic base_sel;
  logic ext_sel;

  always_comb begin
    base_sel = 1'b0;
    case (code)
      GT_ON:     base_sel = 1'b1;
      GT_OFF:    base_sel = 1'b0;
      GT_PIN:    base_sel = pin;
      GT_BACK_N: base_sel = ~back_out;
      default:   base_sel = 1'b0;
    endcase
  end

  always_comb begin
    ext_sel = 1'b0;
    case (code)
      GT_PIN_N:  ext_sel = ~pin;
      GT_BACK:   ext_sel = back_out;
      GT_PAT:    ext_sel = pat;
      GT_OCC:    ext_sel = occ;
      GT_STAY:   ext_sel = ~gone;
      GT_PAT_N:  ext_sel = ~pat;
      GT_OCC_N:  ext_sel = ~occ;
      GT_STAY_N: ext_sel = gone;
      default:   ext_sel = 1'b0;
    endcase
  end

  generate
    if (ENHANCED) begin : g_full
      assign sel = (code > 5'd3) ? ext_sel : base_sel;
    end else begin : g_basic
      assign sel = (code > 5'd3) ? 1'b0 : base_sel;
    end
  endgenerate

endmodule

// File: rtl/ctr_route_matrix.sv
module ctr_route_matrix
  import ctr_route_pkg::*;
#(
  parameter int N_CHIPS  = 2,
  parameter bit ENHANCED = 1'b1,
  localparam int NCH     = N_CHIPS * CH_PER_CHIP,
  localparam int CH_W    = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_is_gate,
  input  logic [CH_W-1:0]      cfg_ch,
  input  logic [CODE_W-1:0]    cfg_wdata,
  input  logic [CH_W-1:0]      rd_ch,
  output logic [CODE_W-1:0]    rd_clk_code,
  output logic [CODE_W-1:0]    rd_gate_code,
  input  logic [N_INT_CE-1:0]  int_ce,
  input  logic [NCH-1:0]       clk_pin_in,
  input  logic [NCH-1:0]       gat_pin_in,
  input  logic [N_CHIPS-1:0]   ext_clk_in,
  input  logic [NCH-1:0]       ctr_out,
  input  logic                 pat_present,
  output logic [NCH-1:0]       sel_clk,
  output logic [NCH-1:0]       sel_gate,
  output logic [NCH-1:0]       clk_pin_oe,
  output logic [NCH-1:0]       clk_pin_out,
  output logic [NCH-1:0]       gat_pin_oe,
  output logic [NCH-1:0]       gat_pin_out
);

  logic [NCH-1:0][CODE_W-1:0] clk_code;
  logic [NCH-1:0][CODE_W-1:0] gate_code;
  logic [NCH-1:0]             gate_wr;
  logic [NCH-1:0]             occ_q;
  logic [NCH-1:0]             gone_q;

  ctr_src_regs #(
    .NCH      (NCH),
    .CH_W     (CH_W),
    .ENHANCED (ENHANCED)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .is_gate      (cfg_is_gate),
    .ch           (cfg_ch),
    .wdata        (cfg_wdata),
    .rd_ch        (rd_ch),
    .clk_code     (clk_code),
    .gate_code    (gate_code),
    .gate_wr      (gate_wr),
    .rd_clk_code  (rd_clk_code),
    .rd_gate_code (rd_gate_code)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      // ring neighbours: one back for the clock, two back for the gate
      localparam int CHIP  = g / CH_PER_CHIP;
      localparam int BACK1 = (g + NCH - 1) % NCH;
      localparam int BACK2 = (g + NCH - 2) % NCH;

      pat_event_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gate_wr[g]),
        .pat    (pat_present),
        .occ_q  (occ_q[g]),
        .gone_q (gone_q[g])
      );

      ctr_clk_mux #(.ENHANCED(ENHANCED)) u_ckmux (
        .code     (clk_code[g]),
        .pin      (clk_pin_in[g]),
        .int_ce   (int_ce),
        .prev_out (ctr_out[BACK1]),
        .ext_clk  (ext_clk_in[CHIP]),
        .pat      (pat_present),
        .sel      (sel_clk[g])
      );

      ctr_gate_mux #(.ENHANCED(ENHANCED)) u_gtmux (
        .code     (gate_code[g]),
        .pin      (gat_pin_in[g]),
        .back_out (ctr_out[BACK2]),
        .pat      (pat_present),
        .occ      (occ_q[g]),
        .gone     (gone_q[g]),
        .sel      (sel_gate[g])
      );

      assign clk_pin_oe[g]  = (clk_code[g] != CK_PIN);
      assign gat_pin_oe[g]  = (gate_code[g] != GT_PIN);
      assign clk_pin_out[g] = sel_clk[g];
      assign gat_pin_out[g] = sel_gate[g];

      // R9: choosing the pin as clock source turns it into an input that feeds the counter
      a_r9_clk_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_is_gate && cfg_ch == CH_W'(g) && cfg_wdata == CK_PIN)
        |=> (!clk_pin_oe[g] && sel_clk[g] == clk_pin_in[g]));

      // R9: same for the gate pin
      a_r9_gat_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_is_gate && cfg_ch == CH_W'(g) && cfg_wdata == GT_PIN)
        |=> (!gat_pin_oe[g] && sel_gate[g] == gat_pin_in[g]));

      // R4: permanent-enable code gives a high gate one edge after the write
      a_r4_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_is_gate && cfg_ch == CH_W'(g) && cfg_wdata == GT_ON)
        |=> sel_gate[g]);
    end
  endgenerate

endmodule

// File: tb/ctr_route_matrix_bench.sv
module ctr_route_matrix_bench;

  localparam int N_CHIPS = 2;
  localparam int NCH     = 6;
  localparam int CH_W    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_is_gate = 1'b0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic [4:0] cfg_wdata = '0;
  logic [CH_W-1:0] rd_ch = '0;
  logic [5:0] int_ce = '0;
  logic [NCH-1:0] clk_pin_in = '0;
  logic [NCH-1:0] gat_pin_in = '0;
  logic [N_CHIPS-1:0] ext_clk_in = '0;
  logic [NCH-1:0] ctr_out = '0;
  logic pat_present = 1'b0;

  logic [4:0] rck_e, rgt_e, rck_b, rgt_b;
  logic [NCH-1:0] sck_e, sgt_e, cko_e, ckd_e, gto_e, gtd_e;
  logic [NCH-1:0] sck_b, sgt_b, cko_b, ckd_b, gto_b, gtd_b;

  int n_chk = 0;
  int n_fail = 0;
  bit pat_en = 1'b0;
  int stored_ck_b [NCH];
  int stored_gt_b [NCH];

  always #2 clk = ~clk;

  ctr_route_matrix #(.N_CHIPS(N_CHIPS), .ENHANCED(1'b1)) u_ctr_route_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_gate(cfg_is_gate),
    .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata), .rd_ch(rd_ch),
    .rd_clk_code(rck_e), .rd_gate_code(rgt_e), .int_ce(int_ce),
    .clk_pin_in(clk_pin_in), .gat_pin_in(gat_pin_in), .ext_clk_in(ext_clk_in),
    .ctr_out(ctr_out), .pat_present(pat_present), .sel_clk(sck_e), .sel_gate(sgt_e),
    .clk_pin_oe(cko_e), .clk_pin_out(ckd_e), .gat_pin_oe(gto_e), .gat_pin_out(gtd_e)
  );

  ctr_route_matrix #(.N_CHIPS(N_CHIPS), .ENHANCED(1'b0)) u_ctr_route_matrix_basic (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_gate(cfg_is_gate),
    .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata), .rd_ch(rd_ch),
    .rd_clk_code(rck_b), .rd_gate_code(rgt_b), .int_ce(int_ce),
    .clk_pin_in(clk_pin_in), .gat_pin_in(gat_pin_in), .ext_clk_in(ext_clk_in),
    .ctr_out(ctr_out), .pat_present(pat_present), .sel_clk(sck_b), .sel_gate(sgt_b),
    .clk_pin_oe(cko_b), .clk_pin_out(ckd_b), .gat_pin_oe(gto_b), .gat_pin_out(gtd_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input bit is_gate, input int ch, input int code);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_is_gate = is_gate;
    cfg_ch = CH_W'(ch);
    cfg_wdata = 5'(code);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic set_inputs(input int k);
    logic [31:0] v;
    v = 32'(k + 1) * 32'h9E3779B1;
    v = v ^ (v >> 15);
    int_ce     = v[5:0];
    clk_pin_in = v[11:6];
    gat_pin_in = v[17:12];
    ext_clk_in = v[19:18];
    ctr_out    = v[25:20];
    if (pat_en) pat_present = v[26];
  endtask

  function automatic int exp_clk(input bit enh, input int code, input int g);
    int chip = g / 3;
    if (code == 0) return int'(clk_pin_in[g]);
    if (code >= 1 && code <= 5) return int'(int_ce[code-1]);
    if (code == 6) return int'(ctr_out[(g + NCH - 1) % NCH]);
    if (code == 7) return int'(ext_clk_in[chip]);
    if (!enh) return 0;
    if (code == 8) return 1;
    if (code == 10) return int'(pat_present);
    if (code == 11) return int'(int_ce[5]);
    return 0;
  endfunction

  function automatic int exp_gate(input bit enh, input int code, input int g,
                                  input int occ, input int gone);
    int back = int'(ctr_out[(g + NCH - 2) % NCH]);
    int pin  = int'(gat_pin_in[g]);
    int pat  = int'(pat_present);
    if (code == 0) return 1;
    if (code == 1) return 0;
    if (code == 2) return pin;
    if (code == 3) return 1 - back;
    if (!enh) return 0;
    case (code)
      6: return 1 - pin;
      7: return back;
      8: return pat;
      9: return occ;
      10: return 1 - gone;
      11: return 1 - pat;
      12: return 1 - occ;
      13: return gone;
      default: return 0;
    endcase
  endfunction

  function automatic string ck_tag(input int code);
    if (code == 6) return "R7";
    if (code <= 7) return "R2";
    return "R3";
  endfunction

  function automatic string gt_tag(input int code);
    if (code == 3 || code == 7) return "R8";
    if (code <= 2) return "R4";
    return "R5";
  endfunction

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int g = 0; g < NCH; g++) begin
      stored_ck_b[g] = 0;
      stored_gt_b[g] = 0;
    end
    set_inputs(17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: state after reset
    for (int g = 0; g < NCH; g++) begin
      rd_ch = CH_W'(g);
      #1;
      chk("R1 clk code", int'(rck_e), 0);
      chk("R1 gate code", int'(rgt_e), 0);
      chk("R1 clk follows pin", int'(sck_e[g]), int'(clk_pin_in[g]));
      chk("R1 gate high", int'(sgt_e[g]), 1);
      chk("R1 clk pin input", int'(cko_e[g]), 0);
      chk("R1 gate pin output", int'(gto_e[g]), 1);
    end
    // R13: out-of-range readback
    rd_ch = 3'd7;
    #1;
    chk("R13 out of range clk", int'(rck_e), 0);
    chk("R13 out of range gate", int'(rgt_e), 0);

    // clock code sweep on every channel
    pat_en = 1'b1;
    for (int g = 0; g < NCH; g++) begin
      rd_ch = CH_W'(g);
      for (int code = 0; code < 32; code++) begin
        wr(1'b0, g, code);
        if (code <= 7) stored_ck_b[g] = code;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          set_inputs(g * 200 + code * 5 + k);
          #1;
          chk("R13 clk readback", int'(rck_e), code);
          chk("R6 basic clk readback", int'(rck_b), stored_ck_b[g]);
          chk(ck_tag(code), int'(sck_e[g]), exp_clk(1'b1, code, g));
          chk(code > 7 ? "R6" : ck_tag(code), int'(sck_b[g]),
              exp_clk(1'b0, stored_ck_b[g], g));
          chk("R9 clk oe", int'(cko_e[g]), (code != 0) ? 1 : 0);
          chk("R9 basic clk oe", int'(cko_b[g]), (stored_ck_b[g] != 0) ? 1 : 0);
          if (cko_e[g]) chk("R9 clk pin drive", int'(ckd_e[g]), exp_clk(1'b1, code, g));
        end
      end
    end

    // gate code sweep, pattern held low so the latches stay empty after each write
    pat_en = 1'b0;
    pat_present = 1'b0;
    for (int g = 0; g < NCH; g++) begin
      rd_ch = CH_W'(g);
      for (int code = 0; code < 32; code++) begin
        wr(1'b1, g, code);
        if (code <= 7) stored_gt_b[g] = code;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          set_inputs(5000 + g * 200 + code * 5 + k);
          #1;
          chk("R13 gate readback", int'(rgt_e), code);
          chk("R6 basic gate readback", int'(rgt_b), stored_gt_b[g]);
          chk(gt_tag(code), int'(sgt_e[g]), exp_gate(1'b1, code, g, 0, 0));
          chk(stored_gt_b[g] > 3 ? "R6" : gt_tag(stored_gt_b[g]), int'(sgt_b[g]),
              exp_gate(1'b0, stored_gt_b[g], g, 0, 0));
          chk("R9 gate oe", int'(gto_e[g]), (code != 2) ? 1 : 0);
          if (gto_e[g]) chk("R9 gate pin drive", int'(gtd_e[g]), exp_gate(1'b1, code, g, 0, 0));
        end
      end
    end

    // latch sequences on channel 1 of the enhanced copy
    wr(1'b1, 1, 9);
    chk("R10 occ clear at start", int'(sgt_e[1]), 0);
    @(negedge clk); pat_present = 1'b1;
    @(negedge clk); pat_present = 1'b0; #1;
    chk("R10 occ set by pulse", int'(sgt_e[1]), 1);
    @(negedge clk); #1;
    chk("R10 occ holds", int'(sgt_e[1]), 1);
    wr(1'b1, 1, 9);
    chk("R12 occ cleared by rewrite", int'(sgt_e[1]), 0);

    wr(1'b1, 1, 10);
    chk("R11 stay high before pattern", int'(sgt_e[1]), 1);
    @(negedge clk); pat_present = 1'b1;
    @(negedge clk); #1;
    chk("R11 stay high while pattern present", int'(sgt_e[1]), 1);
    pat_present = 1'b0;
    @(negedge clk); #1;
    chk("R11 drops after pattern leaves", int'(sgt_e[1]), 0);
    @(negedge clk); #1;
    chk("R11 stays dropped", int'(sgt_e[1]), 0);
    wr(1'b1, 1, 10);
    chk("R12 gone cleared by rewrite", int'(sgt_e[1]), 1);

    wr(1'b1, 1, 13);
    chk("R12 inverted gone after rewrite", int'(sgt_e[1]), 0);
    @(negedge clk); pat_present = 1'b1;
    @(negedge clk); pat_present = 1'b0;
    @(negedge clk); #1;
    chk("R11 inverted gone set", int'(sgt_e[1]), 1);

    wr(1'b1, 1, 12);
    chk("R12 inverted occ after rewrite", int'(sgt_e[1]), 1);
    @(negedge clk); pat_present = 1'b1;
    @(negedge clk); #1;
    chk("R10 inverted occ set", int'(sgt_e[1]), 0);

    wr(1'b1, 1, 8);
    chk("R5 pattern gate live", int'(sgt_e[1]), 1);
    pat_present = 1'b0; #1;
    chk("R5 pattern gate follows", int'(sgt_e[1]), 0);

    // R12: a rejected basic write does not clear: basic copy stays on its last code
    wr(1'b1, 1, 20);
    rd_ch = 3'd1; #1;
    chk("R6 basic ignores wide gate write", int'(rgt_b), stored_gt_b[1]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule